// File: doc/BRIEF.md
# Bit-Serial Crossbar ALU

This block is the arithmetic core of a bit-serial datapath. Sixteen column wires carry one bit each: eight bits shifted out of the datapath registers, the three combinational ALU results, the delay flag, a constant bit, a data bit and two zero wires. Sixteen row wires leave the block. Each row picks one column through its own 4-bit select code. Rows 0 to 7 feed the register inputs. Rows 8 to 12 feed the ALU operands. Row 13 feeds the delay capture.

The ALU handles one bit per clock. It provides an inverter, a two-input AND, and a full-adder sum whose carry is held in a flag register. A delay flag keeps a bit captured in an earlier cycle, so a bit shifted out of a register can be replayed later. Flags change only on a step strobe. A clear strobe starts a new serial word. Carry, delay, and the zero flags for the TOS row, the NOS row and the AND result are exported so a sequencer can branch on them.

Register storage and sequencing sit outside the block.

Top module: `xbar_serial_alu`

## Requirements
- R1: Row r outputs the column chosen by `sel_i[4r+3:4r]`. Columns 0-7 are `reg_bits_i[7:0]`, column 8 is the sum, 9 the AND, 10 the NOT, 11 the delay flag, 12 `const_bit_i`, 13 `data_bit_i`, and columns 14 and 15 are always 0.
- R2: Operand rows 8 to 12 read 0 when they select column 8, 9 or 10, so the ALU never feeds its own inputs.
- R3: The NOT result (column 10) is the inverse of row 8.
- R4: The AND result (column 9) is row 9 AND row 10.
- R5: The sum (column 8) is the carry flag XOR row 11 XOR row 12.
- R6: On a step without clear, the carry flag becomes the majority of the carry flag, row 11 and row 12.
- R7: On a step without clear, the delay flag takes the value of row 13.
- R8: A clear sets carry and delay to 0 and all three zero flags to 1. Clear wins over a simultaneous step.
- R9: On a step without clear, `zero_tos_o`, `zero_nos_o` and `zero_and_o` fall when row 0, row 1 or the AND result is 1, respectively. They stay low until the next clear.
- R10: With neither step nor clear, every flag holds its value.
- R11: After reset, carry and delay are 0 and all zero flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_bits_i | input | 8 | Serial bits of registers 0-7 (columns 0-7) |
| const_bit_i | input | 1 | Constant register bit (column 12) |
| data_bit_i | input | 1 | Data register bit (column 13) |
| sel_i | input | 64 | Column select code, 4 bits per row |
| step_i | input | 1 | Advance flags by one bit cycle |
| clear_i | input | 1 | Start a new word: reset carry and delay, set zero flags |
| row_o | output | 16 | Row wires |
| carry_o | output | 1 | Carry flag |
| delay_o | output | 1 | Delay flag |
| zero_tos_o | output | 1 | No 1 bit seen on row 0 since clear |
| zero_nos_o | output | 1 | No 1 bit seen on row 1 since clear |
| zero_and_o | output | 1 | No 1 bit seen on the AND result since clear |

## Verification
The bench runs full 16-bit serial additions. These include 0xFFFF + 1, whose sum is zero but which must end with carry set and `zero_tos_o` still high. A carry update with the wrong majority would corrupt the upper sum bits, and a zero flag that is not sticky would rise again. The bench drives clear and step together to catch a design that gives step priority, which would leave stale carry and delay values. It points operand rows at the ALU columns to catch a missing mask, which would create a combinational loop or a non-zero operand. It also checks that the fixed columns 14 and 15 read 0 and that the constant and data columns route to their proper positions.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_COLS     = 16;
  localparam int NUM_ROWS     = 16;
  localparam int SEL_W        = $clog2(NUM_COLS);
  localparam int NUM_REG_COLS = 8;
  // column map
  localparam int COL_SUM   = 8;
  localparam int COL_AND   = 9;
  localparam int COL_NOT   = 10;
  localparam int COL_DLY   = 11;
  localparam int COL_CONST = 12;
  localparam int COL_DATA  = 13;
  // row map
  localparam int ROW_TOS     = 0;
  localparam int ROW_NOS     = 1;
  localparam int ROW_NOT_IN  = 8;
  localparam int ROW_AND_A   = 9;
  localparam int ROW_AND_B   = 10;
  localparam int ROW_ADD_A   = 11;
  localparam int ROW_ADD_B   = 12;
  localparam int ROW_DLY_CAP = 13;
  localparam int OP_ROW_LO   = 8;
  localparam int OP_ROW_HI   = 12;
endpackage

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 16,
  parameter int SEL_W    = $clog2(NUM_COLS),
  parameter int OP_LO    = 8,
  parameter int OP_HI    = 12
) (
  input  logic [NUM_COLS-1:0]       col_full_i,
  input  logic [NUM_COLS-1:0]       col_safe_i,
  input  logic [NUM_ROWS*SEL_W-1:0] sel_i,
  output logic [NUM_ROWS-1:0]       row_o
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [SEL_W-1:0] sel;
    assign sel = sel_i[r*SEL_W +: SEL_W];
    if (r >= OP_LO && r <= OP_HI) begin : g_op
      // operand rows see ALU result columns as 0
      assign row_o[r] = col_safe_i[sel];
    end else begin : g_plain
      assign row_o[r] = col_full_i[sel];
    end
  end
endmodule

// File: rtl/xbar_alu.sv
module xbar_alu (
  input  logic not_in_i,
  input  logic and_a_i,
  input  logic and_b_i,
  input  logic add_a_i,
  input  logic add_b_i,
  input  logic carry_i,
  output logic not_o,
  output logic and_o,
  output logic sum_o
);
  assign not_o = ~not_in_i;
  assign and_o = and_a_i & and_b_i;
  assign sum_o = carry_i ^ add_a_i ^ add_b_i;
endmodule

// File: rtl/xbar_flags.sv
module xbar_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic add_a_i,
  input  logic add_b_i,
  input  logic dly_cap_i,
  input  logic tos_bit_i,
  input  logic nos_bit_i,
  input  logic and_bit_i,
  output logic carry_o,
  output logic delay_o,
  output logic zero_tos_o,
  output logic zero_nos_o,
  output logic zero_and_o
);
  logic carry_q, delay_q, ztos_q, znos_q, zand_q;
  logic adv;

  assign adv = step_i & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      delay_q <= 1'b0;
      ztos_q  <= 1'b1;
      znos_q  <= 1'b1;
      zand_q  <= 1'b1;
    end else if (clear_i) begin
      carry_q <= 1'b0;
      delay_q <= 1'b0;
      ztos_q  <= 1'b1;
      znos_q  <= 1'b1;
      zand_q  <= 1'b1;
    end else if (adv) begin
      carry_q <= (carry_q & add_a_i) | (carry_q & add_b_i) | (add_a_i & add_b_i);
      delay_q <= dly_cap_i;
      ztos_q  <= ztos_q & ~tos_bit_i;
      znos_q  <= znos_q & ~nos_bit_i;
      zand_q  <= zand_q & ~and_bit_i;
    end
  end

  assign carry_o    = carry_q;
  assign delay_o    = delay_q;
  assign zero_tos_o = ztos_q;
  assign zero_nos_o = znos_q;
  assign zero_and_o = zand_q;

  AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!carry_q && !delay_q && ztos_q && znos_q && zand_q)); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> ($stable(carry_q) && $stable(delay_q) && $stable(ztos_q)
                               && $stable(znos_q) && $stable(zand_q))); // R10
  AST_ZERO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !ztos_q) |=> !ztos_q); // R9
  AST_CARRY_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && add_a_i && add_b_i) |=> carry_q); // R6
  AST_CARRY_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !add_a_i && !add_b_i) |=> !carry_q); // R6
  AST_DELAY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (delay_q == $past(dly_cap_i))); // R7
endmodule

// File: rtl/xbar_serial_alu.sv
module xbar_serial_alu
  import xbar_pkg::*;
#(
  parameter int ROWS  = NUM_ROWS,
  parameter int COLS  = NUM_COLS,
  parameter int REG_N = NUM_REG_COLS,
  localparam int SW   = $clog2(COLS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_N-1:0]     reg_bits_i,
  input  logic                 const_bit_i,
  input  logic                 data_bit_i,
  input  logic [ROWS*SW-1:0]   sel_i,
  input  logic                 step_i,
  input  logic                 clear_i,
  output logic [ROWS-1:0]      row_o,
  output logic                 carry_o,
  output logic                 delay_o,
  output logic                 zero_tos_o,
  output logic                 zero_nos_o,
  output logic                 zero_and_o
);
  logic [COLS-1:0] col_full, col_safe;
  logic sum_b, and_b, not_b;
  logic carry_q, delay_q;

  always_comb begin
    col_full            = '0;
    col_full[REG_N-1:0] = reg_bits_i;
    col_full[COL_SUM]   = sum_b;
    col_full[COL_AND]   = and_b;
    col_full[COL_NOT]   = not_b;
    col_full[COL_DLY]   = delay_q;
    col_full[COL_CONST] = const_bit_i;
    col_full[COL_DATA]  = data_bit_i;
  end

  always_comb begin
    col_safe            = '0;
    col_safe[REG_N-1:0] = reg_bits_i;
    col_safe[COL_DLY]   = delay_q;
    col_safe[COL_CONST] = const_bit_i;
    col_safe[COL_DATA]  = data_bit_i;
  end

  xbar_matrix #(
    .NUM_ROWS (ROWS),
    .NUM_COLS (COLS),
    .SEL_W    (SW),
    .OP_LO    (OP_ROW_LO),
    .OP_HI    (OP_ROW_HI)
  ) u_matrix (
    .col_full_i (col_full),
    .col_safe_i (col_safe),
    .sel_i      (sel_i),
    .row_o      (row_o)
  );

  xbar_alu u_alu (
    .not_in_i (row_o[ROW_NOT_IN]),
    .and_a_i  (row_o[ROW_AND_A]),
    .and_b_i  (row_o[ROW_AND_B]),
    .add_a_i  (row_o[ROW_ADD_A]),
    .add_b_i  (row_o[ROW_ADD_B]),
    .carry_i  (carry_q),
    .not_o    (not_b),
    .and_o    (and_b),
    .sum_o    (sum_b)
  );

  xbar_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .step_i     (step_i),
    .add_a_i    (row_o[ROW_ADD_A]),
    .add_b_i    (row_o[ROW_ADD_B]),
    .dly_cap_i  (row_o[ROW_DLY_CAP]),
    .tos_bit_i  (row_o[ROW_TOS]),
    .nos_bit_i  (row_o[ROW_NOS]),
    .and_bit_i  (and_b),
    .carry_o    (carry_q),
    .delay_o    (delay_q),
    .zero_tos_o (zero_tos_o),
    .zero_nos_o (zero_nos_o),
    .zero_and_o (zero_and_o)
  );

  assign carry_o = carry_q;
  assign delay_o = delay_q;

  AST_OPERAND_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[ROW_NOT_IN*SW +: SW] == SW'(COL_SUM)) |-> !row_o[ROW_NOT_IN]); // R2
  AST_ZERO_COLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[ROW_TOS*SW +: SW] == SW'(COLS-1)) |-> !row_o[ROW_TOS]); // R1
endmodule

// File: tb/sim_xbar_serial_alu.sv
module sim_xbar_serial_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_bits = '0;
  logic        const_bit = 1'b0, data_bit = 1'b0;
  logic [63:0] sel = '0;
  logic        step = 1'b0, clear = 1'b0;
  logic [15:0] row;
  logic        carry, delay, ztos, znos, zand;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  xbar_serial_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_bits_i(reg_bits), .const_bit_i(const_bit),
    .data_bit_i(data_bit), .sel_i(sel), .step_i(step), .clear_i(clear),
    .row_o(row), .carry_o(carry), .delay_o(delay), .zero_tos_o(ztos),
    .zero_nos_o(znos), .zero_and_o(zand)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_sel(input int r, input int c);
    sel[r*4 +: 4] = 4'(c);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1; step = 1'b0;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    chk({carry, delay, ztos, znos, zand} == 5'b00111, "R11", {carry, delay, ztos, znos, zand}, 5'b00111);
  endtask

  task automatic t_routing();
    @(negedge clk);
    reg_bits = 8'b1010_0110; const_bit = 1'b1; data_bit = 1'b0;
    for (int r = 0; r < 8; r++) set_sel(r, 7 - r);
    set_sel(14, 12); set_sel(15, 13);
    #1;
    chk(row[7:0] == 8'b0110_0101, "R1 reg routing", row[7:0], 8'b0110_0101);
    chk(row[14] == 1'b1 && row[15] == 1'b0, "R1 const/data", row[15:14], 2'b01);
    data_bit = 1'b1; const_bit = 1'b0; #1;
    chk(row[15:14] == 2'b10, "R1 const/data swap", row[15:14], 2'b10);
    set_sel(2, 14); set_sel(3, 15); reg_bits = 8'hFF; #1;
    chk(row[3:2] == 2'b00, "R1 zero columns", row[3:2], 2'b00);
  endtask

  task automatic t_logic();
    @(negedge clk);
    reg_bits = 8'b0000_0101;
    set_sel(8, 0); set_sel(0, 10);     // NOT of bit0
    set_sel(9, 0); set_sel(10, 2); set_sel(1, 9);
    #1;
    chk(row[0] == 1'b0, "R3 not of 1", row[0], 1'b0);
    chk(row[1] == 1'b1, "R4 and 1&1", row[1], 1'b1);
    reg_bits = 8'b0000_0100; #1;
    chk(row[0] == 1'b1, "R3 not of 0", row[0], 1'b1);
    chk(row[1] == 1'b0, "R4 and 0&1", row[1], 1'b0);
    // operand rows picking ALU results read 0
    set_sel(8, 8); #1;
    chk(row[0] == 1'b1, "R2 not_in masked (sum)", row[0], 1'b1);
    set_sel(8, 9); reg_bits = 8'hFF; #1;
    chk(row[0] == 1'b1, "R2 not_in masked (and)", row[0], 1'b1);
    set_sel(9, 10); set_sel(10, 10); #1;
    chk(row[1] == 1'b0, "R2 and operands masked", row[1], 1'b0);
  endtask

  task automatic t_add(input logic [15:0] a, input logic [15:0] b, input logic [16:0] expv);
    logic c = 1'b0;
    logic [15:0] got;
    logic ok = 1'b1;
    sel = '0;
    set_sel(0, 8); set_sel(1, 1); set_sel(11, 0); set_sel(12, 1);
    set_sel(9, 14); set_sel(10, 14); set_sel(13, 0);
    do_clear();
    for (int i = 0; i < 16; i++) begin
      reg_bits = {6'b0, b[i], a[i]}; step = 1'b1; #1;
      got[i] = row[0];
      if (row[0] != (c ^ a[i] ^ b[i])) ok = 1'b0;
      c = (c & a[i]) | (c & b[i]) | (a[i] & b[i]);
      @(negedge clk);
    end
    step = 1'b0; #1;
    chk(ok && got == expv[15:0], "R5 serial sum", got, expv[15:0]);
    chk(carry == expv[16], "R6 carry out", carry, expv[16]);
    chk(ztos == (expv[15:0] == 0), "R9 zero_tos", ztos, expv[15:0] == 0);
    chk(znos == (b == 0), "R9 zero_nos", znos, b == 0);
    chk(zand == 1'b1, "R9 zero_and untouched", zand, 1'b1);
    chk(delay == a[15], "R7 delay holds last bit", delay, a[15]);
  endtask

  task automatic t_delay_and_hold();
    sel = '0; set_sel(13, 0); set_sel(2, 11); set_sel(9, 0); set_sel(10, 0);
    set_sel(11, 0); set_sel(12, 0);
    do_clear();
    reg_bits = 8'h01; step = 1'b1;
    @(negedge clk); step = 1'b0; reg_bits = 8'h00; #1;
    chk(delay == 1'b1 && row[2] == 1'b1, "R7 delay capture", {delay, row[2]}, 2'b11);
    chk(carry == 1'b1 && zand == 1'b0, "R9 zero_and falls", {carry, zand}, 2'b10);
    @(negedge clk); @(negedge clk); #1;
    chk({carry, delay, zand} == 3'b110, "R10 hold", {carry, delay, zand}, 3'b110);
    // clear beats step
    @(negedge clk); clear = 1'b1; step = 1'b1; reg_bits = 8'h01;
    @(negedge clk); clear = 1'b0; step = 1'b0; #1;
    chk({carry, delay, ztos, znos, zand} == 5'b00111, "R8 clear priority",
        {carry, delay, ztos, znos, zand}, 5'b00111);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_routing();
    t_logic();
    t_add(16'h1234, 16'hABCD, 17'h0BE01);
    t_add(16'hFFFF, 16'h0001, 17'h10000);
    t_add(16'h8000, 16'h8000, 17'h10000);
    t_delay_and_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule